// File: doc/BRIEF.md
# Two-Class Priority DRAM Request Scheduler

This block chooses which request of one memory channel's request buffer goes to DRAM next. Each buffer slot holds a request for a bank and row, an arrival stamp from a free-running counter, and one class bit. The class bit marks a request from a core that issued very few memory requests in the previous interval. Software rates every core at each interval end, typically placing a core in the light class when its misses per thousand instructions fell below 1.5. It presents one bit per core on `class_in` and pulses `interval_end`. Only that pulse latches the bits, and each enqueued request copies its core's latched bit. Requests carry no core or application identity beyond this bit.

The scheduler keeps the open row of every bank. Among the valid slots it ranks light-class requests first. Within a class, row-buffer hits come before misses. After that the oldest arrival stamp wins, and the lowest slot index settles any remaining tie. The chosen slot index and its hit status are presented combinationally from registered state. When `issue_en` is high and a selection exists, the slot is freed and its bank's open row becomes the request's row. Upstream logic places each request at a slot index of its choosing. DRAM timing, command sequencing and writes are handled elsewhere. `rst_n` is asserted asynchronously and must be released synchronously to `clk` by the reset tree.

Top module: `dram_prio_sched`

## Requirements
- R1: After reset no slot is valid, no bank has an open row, all latched class bits are 0, and `sel_valid` is 0.
- R2: An enqueue (`enq_valid`=1) to a slot that is not valid stores bank, row, class bit and the next arrival stamp. An enqueue to a slot that is already valid is ignored, and the stored request stays unchanged.
- R3: The class bit of a request is the latched class bit of `enq_core` at the cycle of enqueue. Later changes to the class bits do not alter a stored request.
- R4: The latched class bits take the value of `class_in` only in a cycle with `interval_end`=1. Otherwise they hold.
- R5: If any valid slot has its class bit set, the selection is a slot with its class bit set.
- R6: Among valid slots of the selected class, a row hit is selected over a miss. A request hits when its bank has an open row equal to the request's row.
- R7: Among slots with equal class and hit status, the slot with the oldest arrival stamp is selected (modular comparison), and equal stamps go to the lowest index.
- R8: `sel_hit` is 1 exactly when the selected request is a row hit.
- R9: When `issue_en`=1 and `sel_valid`=1, the selected slot becomes invalid and its bank's open row becomes that request's row from the next cycle. `issue_en` with `sel_valid`=0 changes nothing.
- R10: `sel_valid` is 0 whenever no slot is valid.
- R11: In a cycle that issues slot X, an enqueue to X is ignored, while an enqueue to another free slot is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| interval_end | input | 1 | Latch strobe for the per-core class bits |
| class_in | input | NUM_CORES | Per-core light-class bits from software |
| enq_valid | input | 1 | Enqueue request |
| enq_idx | input | IDX_W | Buffer slot to write |
| enq_core | input | CORE_W | Issuing core of the enqueued request |
| enq_bank | input | BANK_W | Bank of the enqueued request |
| enq_row | input | ROW_W | Row of the enqueued request |
| issue_en | input | 1 | Issue the current selection this cycle |
| sel_valid | output | 1 | A selection exists |
| sel_idx | output | IDX_W | Selected slot index |
| sel_hit | output | 1 | Selected request hits the open row |

## Verification
The hardest case to reach is a collision of all three ranking rules at once. In that case an older light-class miss, a younger normal-class hit and an even older normal-class miss all wait in the same bank. Reaching it needs rows opened by earlier issues, class bits latched at the right moments relative to the enqueues, and a slot that is re-enqueued while it is being issued. The stimulus first builds each of these states with directed sequences. It then runs a long random mix of enqueues, issues and interval strobes over a small row space, so hits are frequent, and a cycle-accurate model checks the choice on every clock.

// File: rtl/dps_pkg.sv
package dps_pkg;
  localparam int unsigned DEF_ENTRIES = 128;
  localparam int unsigned DEF_BANKS   = 4;
  localparam int unsigned DEF_ROW_W   = 14;
  localparam int unsigned DEF_STAMP_W = 16;
  localparam int unsigned DEF_CORES   = 8;
endpackage

// File: rtl/dps_class_reg.sv
module dps_class_reg #(
  parameter int unsigned NUM_CORES = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 interval_end,
  input  logic [NUM_CORES-1:0] class_in,
  output logic [NUM_CORES-1:0] class_q
);
  logic [NUM_CORES-1:0] class_d;

  always_comb begin
    class_d = class_q;
    if (interval_end) class_d = class_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) class_q <= '0;
    else        class_q <= class_d;
  end
endmodule

// File: rtl/dps_entry_buf.sv
module dps_entry_buf #(
  parameter int unsigned N       = 128,
  parameter int unsigned IDX_W   = 7,
  parameter int unsigned BANK_W  = 2,
  parameter int unsigned ROW_W   = 14,
  parameter int unsigned STAMP_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enq_valid,
  input  logic [IDX_W-1:0]   enq_idx,
  input  logic [BANK_W-1:0]  enq_bank,
  input  logic [ROW_W-1:0]   enq_row,
  input  logic               enq_flag,
  input  logic               rel_en,
  input  logic [IDX_W-1:0]   rel_idx,
  output logic [N-1:0]       vld_q,
  output logic [N-1:0]       flag_q,
  output logic [BANK_W-1:0]  bank_q  [N],
  output logic [ROW_W-1:0]   row_q   [N],
  output logic [STAMP_W-1:0] stamp_q [N]
);
  logic [N-1:0]       vld_d;
  logic [N-1:0]       wr_en;
  logic               accept;
  logic [STAMP_W-1:0] cnt_q, cnt_d;

  assign accept = enq_valid && (int'(enq_idx) < N) && !vld_q[enq_idx];

  always_comb begin
    vld_d = vld_q;
    wr_en = '0;
    if (rel_en) vld_d[rel_idx] = 1'b0;
    if (accept) begin
      vld_d[enq_idx] = 1'b1;
      wr_en[enq_idx] = 1'b1;
    end
    cnt_d = accept ? cnt_q + 1'b1 : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      cnt_q <= '0;
    end else begin
      vld_q <= vld_d;
      cnt_q <= cnt_d;
    end
  end

  // Payload registers: write-enabled, no reset (qualified by vld_q).
  always_ff @(posedge clk) begin
    for (int i = 0; i < int'(N); i++) begin
      if (wr_en[i]) begin
        bank_q[i]  <= enq_bank;
        row_q[i]   <= enq_row;
        flag_q[i]  <= enq_flag;
        stamp_q[i] <= cnt_q;
      end
    end
  end
endmodule

// File: rtl/dps_open_rows.sv
module dps_open_rows #(
  parameter int unsigned NB     = 4,
  parameter int unsigned BANK_W = 2,
  parameter int unsigned ROW_W  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic [BANK_W-1:0] upd_bank,
  input  logic [ROW_W-1:0]  upd_row,
  output logic [NB-1:0]     open_vld,
  output logic [ROW_W-1:0]  open_row [NB]
);
  logic [NB-1:0] vld_d;

  always_comb begin
    vld_d = open_vld;
    if (upd_en) vld_d[upd_bank] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) open_vld <= '0;
    else        open_vld <= vld_d;
  end

  always_ff @(posedge clk) begin
    for (int b = 0; b < int'(NB); b++) begin
      if (upd_en && int'(upd_bank) == b) open_row[b] <= upd_row;
    end
  end
endmodule

// File: rtl/dps_pick.sv
module dps_pick #(
  parameter int unsigned N       = 128,
  parameter int unsigned IDX_W   = 7,
  parameter int unsigned NB      = 4,
  parameter int unsigned BANK_W  = 2,
  parameter int unsigned ROW_W   = 14,
  parameter int unsigned STAMP_W = 16
) (
  input  logic [N-1:0]       vld,
  input  logic [N-1:0]       flag,
  input  logic [BANK_W-1:0]  bank     [N],
  input  logic [ROW_W-1:0]   row      [N],
  input  logic [STAMP_W-1:0] stamp    [N],
  input  logic [NB-1:0]      open_vld,
  input  logic [ROW_W-1:0]   open_row [NB],
  output logic               sel_valid,
  output logic [IDX_W-1:0]   sel_idx,
  output logic               sel_hit
);
  localparam int unsigned LVL   = (N > 1) ? $clog2(N) : 0;
  localparam int unsigned P     = 1 << LVL;
  localparam int unsigned NODES = 2 * P - 1;

  logic [NODES-1:0]   nv, nf, nh;
  logic [STAMP_W-1:0] ns [NODES];
  logic [IDX_W-1:0]   ni [NODES];

  for (genvar k = 0; k < int'(P); k++) begin : g_leaf
    localparam int unsigned LN = P - 1 + k;
    if (k < int'(N)) begin : g_real
      assign nv[LN] = vld[k];
      assign nf[LN] = flag[k];
      assign nh[LN] = open_vld[bank[k]] && (open_row[bank[k]] == row[k]);
      assign ns[LN] = stamp[k];
      assign ni[LN] = IDX_W'(k);
    end else begin : g_pad
      assign nv[LN] = 1'b0;
      assign nf[LN] = 1'b0;
      assign nh[LN] = 1'b0;
      assign ns[LN] = '0;
      assign ni[LN] = '0;
    end
  end

  // Left subtree always covers lower indices, so a full tie keeps the left.
  for (genvar n = 0; n < int'(P) - 1; n++) begin : g_node
    localparam int unsigned L = 2 * n + 1;
    localparam int unsigned R = 2 * n + 2;
    logic [STAMP_W-1:0] dlt;
    logic               take_l;
    assign dlt    = ns[L] - ns[R];
    assign take_l = !nv[R]          ? 1'b1 :
                    !nv[L]          ? 1'b0 :
                    (nf[L] != nf[R]) ? nf[L] :
                    (nh[L] != nh[R]) ? nh[L] :
                    (dlt == '0)      ? 1'b1 : dlt[STAMP_W-1];
    assign nv[n] = nv[L] | nv[R];
    assign nf[n] = take_l ? nf[L] : nf[R];
    assign nh[n] = take_l ? nh[L] : nh[R];
    assign ns[n] = take_l ? ns[L] : ns[R];
    assign ni[n] = take_l ? ni[L] : ni[R];
  end

  assign sel_valid = nv[0];
  assign sel_idx   = ni[0];
  assign sel_hit   = nh[0];
endmodule

// File: rtl/dram_prio_sched.sv
module dram_prio_sched
  import dps_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = DEF_ENTRIES,
  parameter int unsigned NUM_BANKS   = DEF_BANKS,
  parameter int unsigned ROW_W       = DEF_ROW_W,
  parameter int unsigned STAMP_W     = DEF_STAMP_W,
  parameter int unsigned NUM_CORES   = DEF_CORES,
  localparam int unsigned IDX_W  = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
  localparam int unsigned BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int unsigned CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 interval_end,
  input  logic [NUM_CORES-1:0] class_in,
  input  logic                 enq_valid,
  input  logic [IDX_W-1:0]     enq_idx,
  input  logic [CORE_W-1:0]    enq_core,
  input  logic [BANK_W-1:0]    enq_bank,
  input  logic [ROW_W-1:0]     enq_row,
  input  logic                 issue_en,
  output logic                 sel_valid,
  output logic [IDX_W-1:0]     sel_idx,
  output logic                 sel_hit
);
  logic [NUM_CORES-1:0]   cls_q;
  logic [NUM_ENTRIES-1:0] ent_vld, ent_flag;
  logic [BANK_W-1:0]      ent_bank  [NUM_ENTRIES];
  logic [ROW_W-1:0]       ent_row   [NUM_ENTRIES];
  logic [STAMP_W-1:0]     ent_stamp [NUM_ENTRIES];
  logic [NUM_BANKS-1:0]   opn_vld;
  logic [ROW_W-1:0]       opn_row   [NUM_BANKS];
  logic                   do_issue;

  assign do_issue = issue_en && sel_valid;

  dps_class_reg #(.NUM_CORES(NUM_CORES)) u_cls (
    .clk(clk), .rst_n(rst_n), .interval_end(interval_end),
    .class_in(class_in), .class_q(cls_q)
  );

  dps_entry_buf #(
    .N(NUM_ENTRIES), .IDX_W(IDX_W), .BANK_W(BANK_W),
    .ROW_W(ROW_W), .STAMP_W(STAMP_W)
  ) u_buf (
    .clk(clk), .rst_n(rst_n),
    .enq_valid(enq_valid), .enq_idx(enq_idx), .enq_bank(enq_bank),
    .enq_row(enq_row), .enq_flag(cls_q[enq_core]),
    .rel_en(do_issue), .rel_idx(sel_idx),
    .vld_q(ent_vld), .flag_q(ent_flag), .bank_q(ent_bank),
    .row_q(ent_row), .stamp_q(ent_stamp)
  );

  dps_open_rows #(.NB(NUM_BANKS), .BANK_W(BANK_W), .ROW_W(ROW_W)) u_rows (
    .clk(clk), .rst_n(rst_n), .upd_en(do_issue),
    .upd_bank(ent_bank[sel_idx]), .upd_row(ent_row[sel_idx]),
    .open_vld(opn_vld), .open_row(opn_row)
  );

  dps_pick #(
    .N(NUM_ENTRIES), .IDX_W(IDX_W), .NB(NUM_BANKS), .BANK_W(BANK_W),
    .ROW_W(ROW_W), .STAMP_W(STAMP_W)
  ) u_pick (
    .vld(ent_vld), .flag(ent_flag), .bank(ent_bank), .row(ent_row),
    .stamp(ent_stamp), .open_vld(opn_vld), .open_row(opn_row),
    .sel_valid(sel_valid), .sel_idx(sel_idx), .sel_hit(sel_hit)
  );
endmodule

// File: rtl/dps_checker.sv
module dps_checker #(
  parameter int unsigned N         = 128,
  parameter int unsigned IDX_W     = 7,
  parameter int unsigned NB        = 4,
  parameter int unsigned BANK_W    = 2,
  parameter int unsigned ROW_W     = 14,
  parameter int unsigned NUM_CORES = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 interval_end,
  input logic                 issue_en,
  input logic                 sel_valid,
  input logic [IDX_W-1:0]     sel_idx,
  input logic                 sel_hit,
  input logic [NUM_CORES-1:0] class_q,
  input logic [N-1:0]         vld,
  input logic [N-1:0]         flag,
  input logic [BANK_W-1:0]    bank     [N],
  input logic [ROW_W-1:0]     row      [N],
  input logic [NB-1:0]        open_vld,
  input logic [ROW_W-1:0]     open_row [NB]
);
  logic              any_vld, any_flag, better_hit;
  logic [BANK_W-1:0] s_bank;
  logic [ROW_W-1:0]  s_row;
  logic              s_flag, s_hit;

  always_comb begin
    s_bank   = bank[sel_idx];
    s_row    = row[sel_idx];
    s_flag   = flag[sel_idx];
    s_hit    = open_vld[s_bank] && (open_row[s_bank] == s_row);
    any_vld  = |vld;
    any_flag = |(vld & flag);
    better_hit = 1'b0;
    for (int i = 0; i < int'(N); i++) begin
      if (vld[i] && flag[i] == s_flag && open_vld[bank[i]] &&
          open_row[bank[i]] == row[i])
        better_hit = 1'b1;
    end
  end

  // R10
  empty_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_vld |-> !sel_valid);
  // R5
  sel_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> vld[sel_idx]);
  // R5
  light_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && any_flag) |-> s_flag);
  // R6
  hit_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && !sel_hit) |-> !better_hit);
  // R8
  hit_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> (sel_hit == s_hit));
  // R9
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_en && sel_valid) |=> !vld[$past(sel_idx)]);
  // R9
  open_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_en && sel_valid) |=>
      (open_vld[$past(s_bank)] && open_row[$past(s_bank)] == $past(s_row)));
  // R4
  class_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !interval_end |=> $stable(class_q));
endmodule

bind dram_prio_sched dps_checker #(
  .N(NUM_ENTRIES), .IDX_W(IDX_W), .NB(NUM_BANKS), .BANK_W(BANK_W),
  .ROW_W(ROW_W), .NUM_CORES(NUM_CORES)
) u_dps_chk (
  .clk(clk), .rst_n(rst_n), .interval_end(interval_end),
  .issue_en(issue_en), .sel_valid(sel_valid), .sel_idx(sel_idx),
  .sel_hit(sel_hit), .class_q(cls_q), .vld(ent_vld), .flag(ent_flag),
  .bank(ent_bank), .row(ent_row), .open_vld(opn_vld), .open_row(opn_row)
);

// File: tb/dram_prio_sched_bench.sv
`timescale 1ns/1ps
module dram_prio_sched_bench;
  localparam int N = 16, NB = 4, ROW_W = 3, STAMP_W = 16, NC = 4;
  localparam int IDX_W = 4, BANK_W = 2, CORE_W = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic interval_end = 1'b0;
  logic [NC-1:0] class_in = '0;
  logic enq_valid = 1'b0, issue_en = 1'b0;
  logic [IDX_W-1:0] enq_idx = '0;
  logic [CORE_W-1:0] enq_core = '0;
  logic [BANK_W-1:0] enq_bank = '0;
  logic [ROW_W-1:0] enq_row = '0;
  logic sel_valid, sel_hit;
  logic [IDX_W-1:0] sel_idx;

  always #2 clk = ~clk;

  dram_prio_sched #(.NUM_ENTRIES(N), .NUM_BANKS(NB), .ROW_W(ROW_W),
                    .STAMP_W(STAMP_W), .NUM_CORES(NC)) u_dram_prio_sched (
    .clk(clk), .rst_n(rst_n), .interval_end(interval_end), .class_in(class_in),
    .enq_valid(enq_valid), .enq_idx(enq_idx), .enq_core(enq_core),
    .enq_bank(enq_bank), .enq_row(enq_row), .issue_en(issue_en),
    .sel_valid(sel_valid), .sel_idx(sel_idx), .sel_hit(sel_hit));

  // Behavioural reference state
  bit m_vld[N]; bit m_flag[N]; int m_bank[N]; int m_row[N]; int m_stamp[N];
  bit m_ovld[NB]; int m_orow[NB]; bit m_class[NC]; int m_cnt;
  int n_cmp = 0, n_bad = 0;
  bit chk_on = 0;
  string req = "R1";

  function automatic void pick(output bit v, output int ix, output bit h);
    v = 0; ix = 0; h = 0;
    for (int i = 0; i < N; i++) begin
      bit hi;
      if (!m_vld[i]) continue;
      hi = m_ovld[m_bank[i]] && m_orow[m_bank[i]] == m_row[i];
      if (!v || (m_flag[i] && !m_flag[ix]) ||
          (m_flag[i] == m_flag[ix] && hi && !h) ||
          (m_flag[i] == m_flag[ix] && hi == h && m_stamp[i] < m_stamp[ix])) begin
        v = 1; ix = i; h = hi;
      end
    end
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_vld[i]) m_vld[i] = 0;
      foreach (m_ovld[b]) m_ovld[b] = 0;
      foreach (m_class[c]) m_class[c] = 0;
      m_cnt = 0;
    end else begin
      bit v; int ix; bit h;
      pick(v, ix, h);
      if (enq_valid && !m_vld[enq_idx]) begin
        m_vld[enq_idx] = 1; m_flag[enq_idx] = m_class[enq_core];
        m_bank[enq_idx] = enq_bank; m_row[enq_idx] = enq_row;
        m_stamp[enq_idx] = m_cnt; m_cnt++;
      end
      if (issue_en && v) begin
        m_vld[ix] = 0; m_ovld[m_bank[ix]] = 1; m_orow[m_bank[ix]] = m_row[ix];
      end
      if (interval_end) foreach (m_class[c]) m_class[c] = class_in[c];
    end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      bit v; int ix; bit h;
      pick(v, ix, h);
      n_cmp++;
      if (sel_valid !== v || (v && (int'(sel_idx) != ix || sel_hit !== h))) begin
        n_bad++;
        $display("FAIL %s: valid/idx/hit actual %0d/%0d/%0d expected %0d/%0d/%0d",
                 req, sel_valid, sel_idx, sel_hit, v, ix, h);
      end
    end
  end

  task automatic check_eq(string r, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic clr();
    enq_valid = 0; issue_en = 0; interval_end = 0;
  endtask
  task automatic tick();
    @(negedge clk); clr();
  endtask
  task automatic enq(int i, int c, int b, int r);
    @(negedge clk); clr();
    enq_valid = 1; enq_idx = i[IDX_W-1:0]; enq_core = c[CORE_W-1:0];
    enq_bank = b[BANK_W-1:0]; enq_row = r[ROW_W-1:0];
  endtask
  task automatic issue();
    @(negedge clk); clr(); issue_en = 1;
  endtask
  task automatic enq_issue(int i, int c, int b, int r);
    enq(i, c, b, r); issue_en = 1;
  endtask
  task automatic strobe(logic [NC-1:0] cls);
    @(negedge clk); clr(); class_in = cls; interval_end = 1;
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk_on = 1;
    // R1 / R10: idle after reset
    tick();
    check_eq("R1", sel_valid, 0);

    // R4 / R3 / R5: class bits latched only on strobe, copied at enqueue
    req = "R4";
    class_in = 4'b0010;
    enq(3, 1, 0, 1);          // core1 not yet latched -> normal
    strobe(4'b0010);
    enq(5, 1, 1, 2);          // light
    class_in = 4'b0000;
    enq(7, 1, 1, 3);          // still light: no strobe since
    tick();
    check_eq("R4", sel_idx, 5);
    check_eq("R5", sel_hit, 0);
    issue(); tick();
    req = "R3";
    check_eq("R3", sel_idx, 7);
    issue(); tick();
    check_eq("R5", sel_idx, 3);
    issue(); tick();
    req = "R10";
    check_eq("R10", sel_valid, 0);
    strobe(4'b0000);

    // R6 / R8: younger hit beats older miss
    req = "R6";
    enq(0, 0, 2, 3); issue(); // opens bank2 row3
    enq(1, 0, 2, 5);
    enq(2, 0, 2, 3);
    tick();
    check_eq("R6", sel_idx, 2);
    check_eq("R8", sel_hit, 1);
    issue(); tick();
    check_eq("R8", sel_idx, 1);
    check_eq("R8", sel_hit, 0);
    issue(); tick();          // bank2 now row5

    // R7: oldest wins over lower index; R2: occupied slot not overwritten
    req = "R7";
    enq(9, 0, 3, 1);
    enq(4, 0, 3, 2);
    tick();
    check_eq("R7", sel_idx, 9);
    req = "R2";
    enq(9, 0, 2, 5);          // would be a hit if accepted
    tick();
    check_eq("R2", sel_idx, 9);
    check_eq("R2", sel_hit, 0);
    issue(); tick();
    issue(); tick();
    check_eq("R9", sel_valid, 0);

    // R9: issue with nothing selected changes nothing
    req = "R9";
    issue(); tick();
    check_eq("R9", sel_valid, 0);

    // R11: same-cycle enqueue and issue
    req = "R11";
    enq(6, 0, 0, 4); tick();
    enq_issue(6, 0, 1, 0); tick();
    check_eq("R11", sel_valid, 0);
    enq(8, 0, 0, 4); tick();
    enq_issue(10, 0, 0, 4); tick();
    check_eq("R11", sel_valid, 1);
    check_eq("R11", sel_idx, 10);
    check_eq("R11", sel_hit, 1);
    issue(); tick();

    // Random mix: R5 R6 R7 ordering under load
    req = "R7";
    for (int t = 0; t < 4000; t++) begin
      @(negedge clk); clr();
      enq_valid = ($urandom_range(1, 0) == 1);
      enq_idx = IDX_W'($urandom_range(N - 1, 0));
      enq_core = CORE_W'($urandom_range(NC - 1, 0));
      enq_bank = BANK_W'($urandom_range(NB - 1, 0));
      enq_row = ROW_W'($urandom_range(3, 0));
      issue_en = ($urandom_range(2, 0) != 0);
      if ($urandom_range(40, 0) == 0) begin
        interval_end = 1; class_in = NC'($urandom_range(15, 0));
      end
    end
    for (int t = 0; t < N + 2; t++) issue();
    tick();
    check_eq("R10", sel_valid, 0);
    chk_on = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule